// File: doc/BRIEF.md
# Single-Pixel-Per-Frame Image Grabber

This block lets a host pull a complete 19 by 19 image of 7-bit pixels out of a sensor one pixel at a time, taking one pixel from each frame. The pixel stream arrives every frame in a fixed readout order, marked by a frame-start pulse and a per-pixel strobe. The block keeps a target index. When the strobe position within the current frame equals that index, it latches the pixel and raises a valid flag. The pixel and flag stay in place until the host reads them.

The host reads through a one-cycle read strobe and gets a byte back. The top bit of that byte says whether a pixel was waiting. A read that returns a pixel moves the target index on by one. A write strobe starts the image over from pixel 0. The host keeps reading until it has received 361 valid bytes. Readout order is column-major: position 0 is a corner, positions 0 to 18 make up the first column, and the next column begins at 19.

Top module: `pix_grab_top`

## Requirements
- R1: During and after synchronous reset, rd_data is 0x00, the target index is 0, and no pixel is captured before the first frame_start.
- R2: A read strobe loads rd_data on the next clock edge with bit 7 set to the valid flag and bits 6:0 set to the held pixel. Without a read strobe, rd_data keeps its value.
- R3: Each frame_start restarts the position count. A strobe in the same cycle as frame_start is position 0, and each later strobe is the next position (position = column*19 + row). Strobes past position 360 never match.
- R4: A pixel is captured only when its position equals the target index, no valid pixel is held, and there has been no capture since the last frame_start. This gives at most one capture per frame.
- R5: A strobe that arrives while a valid pixel is still unread is ignored, and the held pixel value does not change.
- R6: A read that finds a valid pixel clears the flag and advances the index by one. The next capture then waits for a later frame_start.
- R7: A read that finds no valid pixel returns 0x00 and changes neither the index nor the capture state.
- R8: A write strobe sets the index to 0, drops any held pixel, and blocks capture until the next frame_start. It takes priority over a capture or read index update in the same cycle. A read in that same cycle still returns the state from before the write.
- R9: After the pixel at index 360 is read, the index wraps to 0. A full image therefore takes 361 valid reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| pix_strobe | input | 1 | Pixel present on pix_value this cycle |
| pix_value | input | 7 | Pixel value |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe (re-arm) |
| rd_data | output | 8 | Registered read result: {valid, pixel} |

## Verification
The bench uploads a full image over 361 frames and then reads one more pixel to confirm the wrap. A design with an off-by-one end value would either skip pixel 0 or hand back a stale index. Pixel values change from frame to frame, so a grabber that overwrites an unread pixel returns a value from the wrong frame. A grabber that captures twice in one frame advances too early. Two timing cases are covered: a write in the middle of a frame must not allow a capture in that same frame, and frame_start arriving with or without a strobe in the same cycle must put position 0 in the right place.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int DEF_SIDE  = 19;
  localparam int DEF_PIX_W = 7;
endpackage

// File: rtl/pg_frame_pos.sv
module pg_frame_pos #(
  parameter int SIDE  = pg_pkg::DEF_SIDE,
  localparam int NPIX  = SIDE * SIDE,
  localparam int POS_W = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             pix_strobe,
  output logic [POS_W-1:0] cur_pos
);
  logic [POS_W-1:0] cnt_q;

  // position of a strobe in this cycle; frame_start restarts at 0
  assign cur_pos = frame_start ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= POS_W'(NPIX);
    end else if (pix_strobe) begin
      // saturate at NPIX so overlong frames never alias back to low indices
      cnt_q <= (cur_pos == POS_W'(NPIX)) ? cur_pos : cur_pos + 1'b1;
    end else begin
      cnt_q <= cur_pos;
    end
  end
endmodule

// File: rtl/pg_grab_ctrl.sv
module pg_grab_ctrl #(
  parameter int SIDE  = pg_pkg::DEF_SIDE,
  parameter int PIX_W = pg_pkg::DEF_PIX_W,
  localparam int NPIX  = SIDE * SIDE,
  localparam int POS_W = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             pix_strobe,
  input  logic [PIX_W-1:0] pix_value,
  input  logic [POS_W-1:0] cur_pos,
  input  logic             reg_rd,
  input  logic             reg_wr,
  output logic             valid_q,
  output logic [PIX_W-1:0] pix_q,
  output logic [POS_W-1:0] idx_q
);
  logic wait_q;
  logic armed;
  logic take;
  logic [POS_W-1:0] idx_next;

  assign armed    = frame_start || !wait_q;
  assign take     = pix_strobe && armed && !valid_q && (cur_pos == idx_q);
  assign idx_next = (idx_q == POS_W'(NPIX - 1)) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
      pix_q   <= '0;
      wait_q  <= 1'b1;
    end else if (reg_wr) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
      wait_q  <= 1'b1;
    end else begin
      if (frame_start) wait_q <= 1'b0;
      if (take) begin
        valid_q <= 1'b1;
        pix_q   <= pix_value;
        wait_q  <= 1'b1;
      end else if (reg_rd && valid_q) begin
        valid_q <= 1'b0;
        idx_q   <= idx_next;
      end
    end
  end
endmodule

// File: rtl/pix_grab_top.sv
module pix_grab_top #(
  parameter int SIDE  = pg_pkg::DEF_SIDE,
  parameter int PIX_W = pg_pkg::DEF_PIX_W,
  localparam int NPIX  = SIDE * SIDE,
  localparam int POS_W = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             pix_strobe,
  input  logic [PIX_W-1:0] pix_value,
  input  logic             reg_rd,
  input  logic             reg_wr,
  output logic [PIX_W:0]   rd_data
);
  logic [POS_W-1:0] cur_pos;
  logic             valid_w;
  logic [PIX_W-1:0] pix_w;
  logic [POS_W-1:0] idx_w;

  pg_frame_pos #(.SIDE(SIDE)) u_pos (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .pix_strobe(pix_strobe), .cur_pos(cur_pos)
  );

  pg_grab_ctrl #(.SIDE(SIDE), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pix_strobe(pix_strobe),
    .pix_value(pix_value), .cur_pos(cur_pos), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .valid_q(valid_w), .pix_q(pix_w), .idx_q(idx_w)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (reg_rd) rd_data <= valid_w ? {1'b1, pix_w} : '0;
  end
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int PIX_W = 7,
  parameter int NPIX  = 361,
  parameter int POS_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [PIX_W:0]   rd_data,
  input logic             valid_q,
  input logic [PIX_W-1:0] pix_q,
  input logic [POS_W-1:0] idx_q
);
  logic       v_prev, fs_d;
  logic [1:0] caps;
  logic       rose;

  assign rose = valid_q && !v_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_prev <= 1'b0;
      fs_d   <= 1'b0;
      caps   <= '0;
    end else begin
      v_prev <= valid_q;
      fs_d   <= frame_start;
      if (fs_d)      caps <= {1'b0, rose};
      else if (rose) caps <= (caps == 2'd3) ? caps : caps + 2'd1;
    end
  end

  assert_one_per_frame_R4: assert property (@(posedge clk) disable iff (rst)
    caps <= 2'd1);

  assert_hold_unread_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !reg_rd && !reg_wr) |=> (valid_q && $stable(pix_q)));

  assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && valid_q && !reg_wr) |=>
      (!valid_q && idx_q == (($past(idx_q) == POS_W'(NPIX - 1)) ? '0 : $past(idx_q) + 1'b1)));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !valid_q) |=> (rd_data == '0));

  assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (idx_q == '0 && !valid_q));

  assert_index_range_R9: assert property (@(posedge clk) disable iff (rst)
    idx_q < POS_W'(NPIX));
endmodule

bind pix_grab_top pg_checker #(.PIX_W(PIX_W), .NPIX(NPIX), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .rd_data(rd_data), .valid_q(valid_w), .pix_q(pix_w), .idx_q(idx_w)
);

// File: tb/sim_pix_grab_top.sv
`timescale 1ns/1ps
module sim_pix_grab_top;
  localparam int NPIX = 361;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, pix_strobe = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [6:0] pix_value = '0;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, fnum = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference
  int m_pos = NPIX, m_idx = 0, m_pix = 0, m_rd = 0;
  bit m_valid = 0, m_wait = 1;

  always #2 clk = ~clk;

  pix_grab_top u0 (.clk(clk), .rst(rst), .frame_start(frame_start),
    .pix_strobe(pix_strobe), .pix_value(pix_value), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .rd_data(rd_data));

  always @(posedge clk) begin
    int here;
    bit may;
    cyc++;
    if (rst) begin
      m_pos = NPIX; m_idx = 0; m_pix = 0; m_rd = 0; m_valid = 0; m_wait = 1;
    end else begin
      here = frame_start ? 0 : m_pos;
      may  = frame_start || !m_wait;
      if (reg_rd) m_rd = m_valid ? (128 + m_pix) : 0;
      if (reg_wr) begin
        m_idx = 0; m_valid = 0; m_wait = 1;
      end else begin
        if (frame_start) m_wait = 0;
        if (pix_strobe && may && !m_valid && here == m_idx) begin
          m_valid = 1; m_pix = pix_value; m_wait = 1;
        end else if (reg_rd && m_valid) begin
          m_valid = 0; m_idx = (m_idx + 1) % NPIX;
        end
      end
      m_pos = pix_strobe ? ((here < NPIX) ? here + 1 : NPIX) : here;
    end
  end

  always @(negedge clk) begin
    n_chk++;
    if (rd_data !== 8'(m_rd)) begin
      n_bad++;
      $display("FAIL %s per-cycle: rd_data=%h expected=%h", tag, rd_data, 8'(m_rd));
    end
  end

  task automatic check(string t, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [6:0] pv(int k, int f);
    return 7'((k * 3 + f * 11 + 5) & 127);
  endfunction

  task automatic step(bit fs, bit st, logic [6:0] v, bit rd, bit wr);
    @(negedge clk);
    frame_start = fs; pix_strobe = st; pix_value = v; reg_rd = rd; reg_wr = wr;
  endtask

  // frame: optional standalone frame_start cycle, then n strobes
  task automatic frame(int n, bit fs_alone);
    if (fs_alone) step(1, 0, 0, 0, 0);
    for (int k = 0; k < n; k++) step(!fs_alone && k == 0, 1, pv(k, fnum), 0, 0);
    step(0, 0, 0, 0, 0);
    fnum++;
  endtask

  task automatic rd_once(string t, logic [7:0] exp);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    check(t, rd_data, exp);
  endtask

  initial begin
    repeat (3) step(0, 0, 0, 0, 0);
    check("R1 reset value", rd_data, 8'h00);
    rst = 0;
    tag = "R1";
    // strobes before any frame_start must not capture
    for (int k = 0; k < 4; k++) step(0, 1, 7'h55, 0, 0);
    rd_once("R1 no capture before first frame", 8'h00);

    tag = "R3";
    frame(NPIX, 0);
    rd_once("R3 position 0 with coinciding strobe", {1'b1, pv(0, fnum - 1)});
    tag = "R7";
    rd_once("R7 empty read", 8'h00);
    check("R2 rd_data holds without read", rd_data, 8'h00);

    tag = "R3";
    frame(NPIX, 1);
    rd_once("R3 index 1 with standalone frame start", {1'b1, pv(1, fnum - 1)});

    tag = "R5";
    frame(NPIX, 0);          // captures index 2
    frame(NPIX, 0);          // must be ignored
    rd_once("R5 unread pixel kept", {1'b1, pv(2, fnum - 2)});

    tag = "R4";
    frame(NPIX, 0);          // captures index 3
    rd_once("R4 capture index 3", {1'b1, pv(3, fnum - 1)});
    // more strobes in same frame after read: no second capture
    for (int k = 0; k < 10; k++) step(0, 1, 7'h11, 0, 0);
    rd_once("R6 no capture before next frame", 8'h00);

    tag = "R8";
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);     // write mid-frame
    for (int k = 0; k < NPIX; k++) step(0, 1, 7'h22, 0, 0);
    rd_once("R8 no capture in write frame", 8'h00);
    frame(NPIX, 0);
    rd_once("R8 rearmed to pixel 0", {1'b1, pv(0, fnum - 1)});
    frame(NPIX, 0);          // index 1 captured, then write+read same cycle
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0);
    check("R8 read with write returns prior state", rd_data, {1'b1, pv(1, fnum - 1)});
    rd_once("R8 write dropped held pixel", 8'h00);

    tag = "R9";
    for (int f = 0; f < NPIX; f++) begin
      frame(NPIX, 0);
      rd_once("R9 upload pixel", {1'b1, pv(f, fnum - 1)});
    end
    frame(NPIX, 0);
    rd_once("R9 wrap to pixel 0", {1'b1, pv(0, fnum - 1)});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 195000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: cycles=%0d expected=<195000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule